// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers one-cycle event pulses from up to sixteen sources into a sticky flag register. A separate enable register selects which of those flags may pull the interrupt line low. The interrupt output is active low, in the style of an open-drain request line. A host on a simple register bus can inspect the flags through two read views. The plain view only reports the flags. The clearing view reports the same content and then empties the register, which releases the line.

Flags capture their events whether or not the matching enable bit is set. Software can therefore poll sources it has chosen not to be interrupted by. Source 0 is wired, by convention, to the "waveform sample available" event. The other sources are generic. An event that lands in the same cycle as a clearing read is kept. It is never lost between the read and the clear.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every flag is 0, the enable register is 0, the interrupt output is 1 (released) and the read data is 0.
- R2: A one-cycle pulse on bit k of the event input sets flag k at the next clock edge.
- R3: A flag is set by its event even when its enable bit is 0, and in that case the interrupt output stays 1.
- R4: The interrupt output is 0 in every cycle where some flag and its enable bit are both 1, and 1 otherwise.
- R5: A read at address 1 (plain status view) returns the flags and changes neither the flags nor the interrupt output.
- R6: A read at address 2 (clearing status view) returns the flags as they were before the read and clears all of them at the same edge, so the interrupt output returns to 1 unless a new event arrived in that cycle.
- R7: An event pulse in the same cycle as a clearing read leaves its flag set after the read.
- R8: A write at address 0 loads the enable register, which reads back at address 0; writes to addresses 1 and 2 change nothing.
- R9: Read data is registered and appears one cycle after the read strobe; a read of any address other than 0, 1 or 2 returns 0.
- R10: Flags stay set, with no further events, until a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 16 | Event pulses, one per source; bit 0 is the waveform sample event |
| addr_i | input | 4 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
A lost or spurious flag shows in the plain view on the next read. Once the bit is enabled, it also shows on the interrupt line in the cycle right after the edge that corrupted it. A clear that fires at the wrong time, or drops a same-cycle event, shows in the plain view that follows a clearing read. A corrupted enable register shows in the mask readback, and it leaves the line held low or released against the flag pattern from the next cycle on.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned N_SRC  = 16;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 4'd0,
        REG_FLAGS  = 4'd1,
        REG_FLAGS_CLR = 4'd2
    } reg_sel_e;

    typedef struct packed {
        logic rd_en;
        logic rd_flags;
        logic rd_clr;
        logic wr_en;
    } bus_dec_t;

    function automatic bus_dec_t decode(input logic [ADDR_W-1:0] a,
                                        input logic rd, input logic wr);
        bus_dec_t d;
        d.rd_en    = rd && (a == REG_ENABLE);
        d.rd_flags = rd && (a == REG_FLAGS);
        d.rd_clr   = rd && (a == REG_FLAGS_CLR);
        d.wr_en    = wr && (a == REG_ENABLE);
        return d;
    endfunction
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
#(
    parameter int unsigned N = N_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (evt[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
    import irqc_pkg::*;
#(
    parameter int unsigned N = N_SRC,
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [N-1:0] en
);
    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (load)
            en <= wdata[N-1:0];
    end
endmodule

// File: rtl/irqc_rdport.sv
module irqc_rdport
    import irqc_pkg::*;
#(
    parameter int unsigned N = N_SRC,
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_dec_t     dec,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic [W-1:0] rdata
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = '0;
        if (dec.rd_en)
            nxt[N-1:0] = en;
        else if (dec.rd_flags || dec.rd_clr)
            nxt[N-1:0] = flags;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= nxt;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_n_o
);
    bus_dec_t         dec;
    logic [N_SRC-1:0] flags_q;
    logic [N_SRC-1:0] mask_q;

    assign dec = decode(addr_i, rd_i, wr_i);

    irqc_flags #(.N(N_SRC)) u_flags (
        .clk(clk), .rst(rst), .evt(evt_i), .clr(dec.rd_clr), .flags(flags_q)
    );

    irqc_enable #(.N(N_SRC), .W(DATA_W)) u_enable (
        .clk(clk), .rst(rst), .load(dec.wr_en), .wdata(wdata_i), .en(mask_q)
    );

    irqc_rdport #(.N(N_SRC), .W(DATA_W)) u_rd (
        .clk(clk), .rst(rst), .dec(dec), .flags(flags_q), .en(mask_q),
        .rdata(rdata_o)
    );

    assign irq_n_o = ~|(flags_q & mask_q);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [N_SRC-1:0]  evt_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_n_o,
    input logic [N_SRC-1:0]  flags_q,
    input logic [N_SRC-1:0]  mask_q
);
    logic clr_rd, plain_rd, odd_rd;
    assign clr_rd   = rd_i && (addr_i == 4'd2);
    assign plain_rd = rd_i && (addr_i == 4'd1);
    assign odd_rd   = rd_i && (addr_i > 4'd2);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(evt_i)) == $past(evt_i))); // R2

    AST_CLR_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
        clr_rd |=> (flags_q == $past(evt_i))); // R7

    AST_CLR_RETURNS: assert property (@(posedge clk) disable iff (rst)
        clr_rd |=> (rdata_o[N_SRC-1:0] == $past(flags_q))); // R6

    AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (clr_rd && evt_i == '0) |=> irq_n_o); // R6

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!clr_rd && evt_i == '0) |=> $stable(flags_q)); // R10

    AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (plain_rd && evt_i == '0) |=> ($stable(flags_q) && $stable(irq_n_o))); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && addr_i == 4'd0) |=> $stable(mask_q)); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        odd_rd |=> (rdata_o == '0)); // R9
endmodule

bind irq_status_ctrl irqc_chk u_chk (
    .clk(clk), .rst(rst), .evt_i(evt_i), .addr_i(addr_i), .rd_i(rd_i),
    .wr_i(wr_i), .rdata_o(rdata_o), .irq_n_o(irq_n_o),
    .flags_q(flags_q), .mask_q(mask_q)
);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] evt_i;
    logic [3:0]  addr_i;
    logic        rd_i, wr_i;
    logic [15:0] wdata_i;
    logic [15:0] rdata_o;
    logic        irq_n_o;
    int          n_run = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctrl u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i), .addr_i(addr_i), .rd_i(rd_i),
        .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_n_o(irq_n_o)
    );

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read: strobe for one cycle, data sampled at the following negedge.
    task automatic bus_read(input logic [3:0] a, input logic [15:0] ev,
                            output logic [15:0] d);
        @(negedge clk);
        addr_i = a; rd_i = 1'b1; evt_i = ev;
        @(negedge clk);
        rd_i = 1'b0; evt_i = '0;
        d = rdata_o;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        addr_i = a; wr_i = 1'b1; wdata_i = v;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 irq after reset", {15'd0, irq_n_o}, 16'd1);
        check("R1 rdata after reset", rdata_o, 16'h0000);
        bus_read(4'd0, '0, d); check("R1 mask after reset", d, 16'h0000);
        bus_read(4'd1, '0, d); check("R1 flags after reset", d, 16'h0000);
    endtask

    task automatic t_unmasked();
        logic [15:0] d;
        pulse(16'h0001);
        check("R3 irq stays released when masked", {15'd0, irq_n_o}, 16'd1);
        bus_read(4'd1, '0, d); check("R2 sample flag set", d, 16'h0001);
        bus_read(4'd1, '0, d); check("R5 plain read no side effect", d, 16'h0001);
        pulse(16'hA5A0);
        repeat (3) @(negedge clk);
        bus_read(4'd1, '0, d); check("R10 flags sticky", d, 16'hA5A1);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        bus_write(4'd0, 16'h0002);
        check("R4 irq released, no enabled flag", {15'd0, irq_n_o}, 16'd1);
        bus_read(4'd0, '0, d); check("R8 mask readback", d, 16'h0002);
        bus_write(4'd0, 16'h0001);
        check("R4 irq asserted", {15'd0, irq_n_o}, 16'd0);
        bus_read(4'd1, '0, d);
        check("R5 irq unchanged by plain read", {15'd0, irq_n_o}, 16'd0);
    endtask

    task automatic t_clear();
        logic [15:0] d;
        bus_read(4'd2, '0, d); check("R6 clearing view content", d, 16'hA5A1);
        check("R6 irq released after clear", {15'd0, irq_n_o}, 16'd1);
        bus_read(4'd1, '0, d); check("R6 flags cleared", d, 16'h0000);
    endtask

    task automatic t_race();
        logic [15:0] d;
        bus_write(4'd0, 16'h0020);
        pulse(16'h0008);
        bus_read(4'd2, 16'h0020, d); check("R7 clear returns old flags", d, 16'h0008);
        check("R7 irq held by same-cycle event", {15'd0, irq_n_o}, 16'd0);
        bus_read(4'd1, '0, d); check("R7 same-cycle event kept", d, 16'h0020);
    endtask

    task automatic t_ignore();
        logic [15:0] d;
        bus_write(4'd1, 16'hFFFF);
        bus_write(4'd2, 16'h0000);
        bus_read(4'd1, '0, d); check("R8 status writes ignored", d, 16'h0020);
        bus_read(4'd0, '0, d); check("R8 mask kept", d, 16'h0020);
        bus_read(4'd7, '0, d); check("R9 unmapped reads zero", d, 16'h0000);
        @(negedge clk);
        addr_i = 4'd1; rd_i = 1'b1;
        check("R9 data not yet valid", d, 16'h0000);
        @(negedge clk);
        rd_i = 1'b0;
        check("R9 one-cycle read latency", rdata_o, 16'h0020);
    endtask

    initial begin
        rst = 1'b1; evt_i = '0; addr_i = '0; rd_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unmasked();
        t_mask();
        t_clear();
        t_race();
        t_ignore();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule